// File: doc/BRIEF.md
# UART Queue-Level Interrupt Controller

This block turns the state of a serial port's two 16-character queues and the error pulses of its receiver into one interrupt request. A receive-level source is raised when the receive queue holds at least its programmed trigger level. A transmit-level source is raised when the transmit queue has drained to or below its own trigger level. Each trigger is chosen separately as a fraction of the queue depth. A receive-timeout source reports characters left in the receive queue below the trigger while no traffic has occurred for 32 bit periods. Four receiver error events are latched as separate sources.

Software sees a raw status word and a masked status word. It enables sources through a mask and removes latched error events by writing ones. The single interrupt output is the OR of all enabled pending sources. The queues, the serial shifters and the register decoding are outside the block. They supply the fill levels, the push and pop strobes, the bit-rate tick and the decoded write strobe.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit 0 (receive level) is 1 exactly when `rx_level` >= the receive threshold. Select code 0,1,2,3,4 gives 2,4,8,12,14 characters (1/8, 1/4, 1/2, 3/4, 7/8 of 16). This bit follows the inputs combinationally.
- R2: Status bit 1 (transmit level) is 1 exactly when `tx_level` <= the transmit threshold, which is encoded the same way as in R1.
- R3: With receive select 1 (1/4), bit 0 is 0 at three characters and 1 at four. Select codes 5, 6 and 7 behave as code 4 (14 characters).
- R4: Status bit 2 (receive timeout) is 1 when `rx_level` is non-zero, `rx_level` is below the receive threshold, and 32 `baud_tick` pulses have been counted since the last restart.
- R5: The timeout count restarts on any cycle with `rx_push`, `rx_pop` or `rx_level` equal to 0, and it stops counting at 32. A clear write has no effect on bit 2 or on the level bits 0 and 1.
- R6: A one-cycle pulse on `err_overrun`, `err_break`, `err_parity` or `err_frame` sets status bit 3, 4, 5 or 6 respectively from the next cycle on. The bit stays set until it is cleared.
- R7: When `clr_wr` is 1, each error bit whose `clr_data` bit is 1 is cleared on the next cycle. An error pulse in the same cycle wins over the clear.
- R8: `masked_status` equals `raw_status` AND `int_mask`, bit for bit.
- R9: `irq` is 1 exactly when any bit of `masked_status` is 1.
- R10: After reset, all error bits are 0 and the timeout count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 5 | Receive queue fill, 0..16 |
| tx_level | input | 5 | Transmit queue fill, 0..16 |
| rx_trig_sel | input | 3 | Receive trigger fraction code |
| tx_trig_sel | input | 3 | Transmit trigger fraction code |
| rx_push | input | 1 | A character entered the receive queue |
| rx_pop | input | 1 | A character was read from the receive queue |
| baud_tick | input | 1 | One pulse per bit period |
| err_overrun | input | 1 | Receiver overrun pulse |
| err_break | input | 1 | Line break pulse |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| int_mask | input | 7 | Per-source enable |
| clr_wr | input | 1 | Clear write strobe |
| clr_data | input | 7 | Write-one-to-clear data |
| raw_status | output | 7 | Unmasked pending sources |
| masked_status | output | 7 | Enabled pending sources |
| irq | output | 1 | Merged interrupt request |

## Verification
The timeout is the hardest source to reach. It needs 32 bit ticks with no push or pop while the receive fill stays between one character and the trigger, so random traffic almost never produces it. The stimulus therefore holds the fill below the trigger and issues a tick every cycle for more than 32 cycles. It then breaks the wait with a push and a pop, and it tries a clear write while the source is set. A random phase that pulses errors and clear writes at the same time covers the case where setting and clearing collide.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N   = 7;
  localparam int SRC_RX  = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_TO  = 2;
  localparam int SRC_OVR = 3;
  localparam int SRC_BRK = 4;
  localparam int SRC_PAR = 5;
  localparam int SRC_FRM = 6;
  localparam int ERR_LO  = SRC_OVR;
  localparam int ERR_N   = 4;

  // Trigger fraction in eighths of the queue depth.
  function automatic int unsigned trig_eighths(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      default: return 7;
    endcase
  endfunction

  function automatic int unsigned trig_chars(input logic [2:0] sel, input int unsigned depth);
    return (depth * trig_eighths(sel)) / 8;
  endfunction
endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [2:0]       rx_trig_sel,
  input  logic [2:0]       tx_trig_sel,
  output logic             rx_hit,
  output logic             tx_hit,
  output logic             rx_lingering
);
  logic [LVL_W-1:0] rx_thr;
  logic [LVL_W-1:0] tx_thr;

  always_comb begin
    rx_thr       = LVL_W'(trig_chars(rx_trig_sel, DEPTH));
    tx_thr       = LVL_W'(trig_chars(tx_trig_sel, DEPTH));
    rx_hit       = (rx_level >= rx_thr);
    tx_hit       = (tx_level <= tx_thr);
    rx_lingering = (rx_level != '0) && (rx_level < rx_thr);
  end
endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
  parameter int TO_TICKS = 32,
  localparam int CNT_W = $clog2(TO_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  input  logic arm,
  output logic expired
);
  logic [CNT_W-1:0] idle_cnt;
  logic             at_limit;

  assign at_limit = (idle_cnt == CNT_W'(TO_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (restart)
      idle_cnt <= '0;
    else if (tick && !at_limit)
      idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired = arm && at_limit;
endmodule

// File: rtl/irq_err_latch.sv
module irq_err_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic [N-1:0] clr_pulse,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else
        flags[i] <= set_pulse[i] | (flags[i] & ~clr_pulse[i]);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_TICKS = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [2:0]       rx_trig_sel,
  input  logic [2:0]       tx_trig_sel,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             baud_tick,
  input  logic             err_overrun,
  input  logic             err_break,
  input  logic             err_parity,
  input  logic             err_frame,
  input  logic [SRC_N-1:0] int_mask,
  input  logic             clr_wr,
  input  logic [SRC_N-1:0] clr_data,
  output logic [SRC_N-1:0] raw_status,
  output logic [SRC_N-1:0] masked_status,
  output logic             irq
);
  logic             rx_hit;
  logic             tx_hit;
  logic             rx_lingering;
  logic             to_restart;
  logic             to_expired;
  logic [ERR_N-1:0] err_set;
  logic [ERR_N-1:0] err_clr;
  logic [ERR_N-1:0] err_flags;

  irq_level_cmp #(.DEPTH(DEPTH)) u_cmp (
    .rx_level    (rx_level),
    .tx_level    (tx_level),
    .rx_trig_sel (rx_trig_sel),
    .tx_trig_sel (tx_trig_sel),
    .rx_hit      (rx_hit),
    .tx_hit      (tx_hit),
    .rx_lingering(rx_lingering)
  );

  assign to_restart = rx_push | rx_pop | (rx_level == '0);

  irq_rx_timeout #(.TO_TICKS(TO_TICKS)) u_to (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(to_restart),
    .tick   (baud_tick),
    .arm    (rx_lingering),
    .expired(to_expired)
  );

  assign err_set = {err_frame, err_parity, err_break, err_overrun};
  assign err_clr = clr_wr ? clr_data[ERR_LO +: ERR_N] : '0;

  irq_err_latch #(.N(ERR_N)) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pulse(err_set),
    .clr_pulse(err_clr),
    .flags    (err_flags)
  );

  always_comb begin
    raw_status                 = '0;
    raw_status[SRC_RX]         = rx_hit;
    raw_status[SRC_TX]         = tx_hit;
    raw_status[SRC_TO]         = to_expired;
    raw_status[ERR_LO +: ERR_N] = err_flags;
  end

  assign masked_status = raw_status & int_mask;
  assign irq           = |masked_status;
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic             rx_push,
  input logic             err_overrun,
  input logic             err_frame,
  input logic [SRC_N-1:0] int_mask,
  input logic             clr_wr,
  input logic [SRC_N-1:0] clr_data,
  input logic [SRC_N-1:0] raw_status,
  input logic [SRC_N-1:0] masked_status,
  input logic             irq
);
  p_mask_and_r8: assert property (@(posedge clk) disable iff (!rst_n)
    masked_status == (raw_status & int_mask));

  p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (masked_status != '0));

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun |=> raw_status[SRC_OVR]);

  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[SRC_FRM] && !(clr_wr && clr_data[SRC_FRM])) |=> raw_status[SRC_FRM]);

  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[SRC_OVR] && !err_overrun) |=> !raw_status[SRC_OVR]);

  p_to_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !raw_status[SRC_TO]);

  p_to_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !raw_status[SRC_TO]);
endmodule

bind uart_irq_ctrl uart_irq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_level     (rx_level),
  .rx_push      (rx_push),
  .err_overrun  (err_overrun),
  .err_frame    (err_frame),
  .int_mask     (int_mask),
  .clr_wr       (clr_wr),
  .clr_data     (clr_data),
  .raw_status   (raw_status),
  .masked_status(masked_status),
  .irq          (irq)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rx_level = '0, tx_level = '0;
  logic [2:0] rx_trig_sel = '0, tx_trig_sel = '0;
  logic       rx_push = 0, rx_pop = 0, baud_tick = 0;
  logic       err_overrun = 0, err_break = 0, err_parity = 0, err_frame = 0;
  logic [6:0] int_mask = '0;
  logic       clr_wr = 0;
  logic [6:0] clr_data = '0;
  logic [6:0] raw_status, masked_status;
  logic       irq;

  int checks = 0;
  int failures = 0;
  logic [6:0] m_err = '0;   // model error bits in positions 3..6
  int         m_cnt = 0;    // model idle tick count

  uart_irq_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int thr_of(input logic [2:0] sel);
    if (sel >= 3'd4) return 14;
    return (sel == 3'd0) ? 2 : (sel == 3'd1) ? 4 : (sel == 3'd2) ? 8 : 12;
  endfunction

  function automatic logic [6:0] exp_raw();
    logic [6:0] e;
    int rt;
    rt = thr_of(rx_trig_sel);
    e = m_err;
    e[0] = (int'(rx_level) >= rt);
    e[1] = (int'(tx_level) <= thr_of(tx_trig_sel));
    e[2] = (rx_level != 0) && (int'(rx_level) < rt) && (m_cnt == 32);
    return e;
  endfunction

  function automatic string bit_req(input int b);
    case (b)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, tag, $time, act, exp);
    end
  endtask

  // Inputs are set just after a falling edge; sample, check, advance model, move to next falling edge.
  task automatic step(input string tag);
    logic [6:0] e;
    logic [6:0] errin;
    #1;
    e = exp_raw();
    for (int b = 0; b < 7; b++) chk(bit_req(b), tag, int'(raw_status[b]), int'(e[b]));
    chk("R8", tag, int'(masked_status), int'(e & int_mask));
    chk("R9", tag, int'(irq), int'((e & int_mask) != 0));
    errin = {err_frame, err_parity, err_break, err_overrun, 3'b000};
    m_err = errin | (m_err & ~(clr_wr ? (clr_data & 7'b1111000) : 7'b0));
    if (rx_push || rx_pop || rx_level == 0) m_cnt = 0;
    else if (baud_tick && m_cnt < 32) m_cnt++;
    @(negedge clk);
  endtask

  task automatic quiet();
    rx_push = 0; rx_pop = 0; baud_tick = 0; clr_wr = 0; clr_data = '0;
    err_overrun = 0; err_break = 0; err_parity = 0; err_frame = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: after reset no errors latched, timer idle, tx level source up at empty queue
    int_mask = 7'h7f;
    step("R10");
    chk("R10", "reset", int'(raw_status), 7'b0000010);

    // R1 / R3: threshold sweep on receive side
    for (int s = 0; s < 8; s++) begin
      rx_trig_sel = 3'(s);
      rx_level = 5'(thr_of(3'(s)) - 1); step("R1 below");
      rx_level = 5'(thr_of(3'(s)));     step("R1 at");
    end
    rx_trig_sel = 3'd1; rx_level = 5'd3; #1 chk("R3", "quarter three", int'(raw_status[0]), 0);
    @(negedge clk);
    rx_level = 5'd4; #1 chk("R3", "quarter four", int'(raw_status[0]), 1);
    @(negedge clk);
    rx_trig_sel = 3'd6; rx_level = 5'd13; step("R3 code6");
    rx_level = 5'd14; step("R3 code6");
    // R2 transmit sweep
    for (int s = 0; s < 5; s++) begin
      tx_trig_sel = 3'(s);
      tx_level = 5'(thr_of(3'(s)));     step("R2 at");
      tx_level = 5'(thr_of(3'(s)) + 1); step("R2 above");
    end

    // R4 / R5: timeout, directed
    rx_trig_sel = 3'd2; rx_level = 5'd3; baud_tick = 1;
    for (int i = 0; i < 40; i++) step("R4 wait");
    chk("R4", "expired", int'(raw_status[2]), 1);
    clr_wr = 1; clr_data = 7'h7f; step("R5 clear ignored");
    clr_wr = 0; clr_data = '0;
    chk("R5", "timeout stays", int'(raw_status[2]), 1);
    rx_push = 1; step("R5 push"); rx_push = 0;
    chk("R5", "restart push", int'(raw_status[2]), 0);
    for (int i = 0; i < 33; i++) step("R4 wait2");
    rx_pop = 1; step("R5 pop"); rx_pop = 0;
    chk("R5", "restart pop", int'(raw_status[2]), 0);
    baud_tick = 0;

    // R6 / R7: error latch directed
    err_parity = 1; step("R6 set"); err_parity = 0; step("R6 held");
    chk("R6", "parity held", int'(raw_status[5]), 1);
    err_overrun = 1; clr_wr = 1; clr_data = 7'b0001000; step("R7 collide");
    quiet(); step("R7 set wins");
    chk("R7", "set wins", int'(raw_status[3]), 1);
    clr_wr = 1; clr_data = 7'b0101000; step("R7 clear"); quiet(); step("R7 after");
    chk("R7", "cleared", int'(raw_status[5:3]), 0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      rx_level = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 7) != 0 && i > 0) rx_level = rx_level; 
      tx_level = 5'($urandom_range(0, 16));
      rx_trig_sel = 3'($urandom_range(0, 7));
      tx_trig_sel = 3'($urandom_range(0, 7));
      rx_push = ($urandom_range(0, 15) == 0);
      rx_pop = ($urandom_range(0, 15) == 0);
      baud_tick = ($urandom_range(0, 1) == 0);
      err_overrun = ($urandom_range(0, 9) == 0);
      err_break = ($urandom_range(0, 9) == 0);
      err_parity = ($urandom_range(0, 9) == 0);
      err_frame = ($urandom_range(0, 9) == 0);
      int_mask = 7'($urandom);
      clr_wr = ($urandom_range(0, 3) == 0);
      clr_data = 7'($urandom);
      if (i % 200 < 60) begin  // hold a lingering fill so timeouts occur
        rx_trig_sel = 3'd3; rx_level = 5'd5; rx_push = 0; rx_pop = 0; baud_tick = 1;
      end
      step("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule